// File: doc/BRIEF.md
# Outer CHR Address Composer

This block builds pattern-memory address bits A20..A10 for a cartridge bank-switching controller. It merges three sources: an 8-bit outer CHR base register written by the CPU, the 1 KiB bank number produced by a separate inner bank controller, and, where required, a 2-bit latch loaded by CPU writes to the upper half of the CPU address space. The PPU's own address bits A12..A10 fill in the low bits in the regimes that do not use inner banking.

Three mode bits choose the regime, and they come from a mode register held outside the block:

- **Source select** chooses between inner-controller banking and PPU-driven low bits.
- **Latch disable** turns the latch off. It doubles as the ROM/RAM choice while inner banking is active.
- **Size** moves the split between the outer bits and the inner bits by one position.

The composed address is combinational from the stored registers and the live inputs. The block also produces a pattern-memory RAM select.

Top module: `outer_chr_composer`

## Requirements
- R1: The base register resets to 0x00. It loads the whole data byte on a CPU write whose address, ANDed with 0xF013, equals 0x5002.
- R2: Source select = 0 and size = 0: chr_addr = {base[7:5], inner_bank[7:0]}.
- R3: Source select = 0 and size = 1: chr_addr = {base[7:4], inner_bank[6:0]}.
- R4: Source select = 1, latch disable = 0, size = 0: chr_addr = {base[7:2], latch[1:0], ppu_addr[12:10]}.
- R5: Source select = 1, latch disable = 0, size = 1: chr_addr = {base[7:1], latch[0], ppu_addr[12:10]}.
- R6: Source select = 1 and latch disable = 1: chr_addr = {base[7:0], ppu_addr[12:10]}, independent of size. This gives a fixed 8 KiB bank.
- R7: The latch resets to 0. It loads cpu_data[1:0] on any CPU write with cpu_addr[15] = 1, but only while source select = 1 and latch disable = 0. At all other times it holds its value.
- R8: chr_ram_sel equals the latch-disable bit while source select = 0. It is 0 while source select = 1.
- R9: The base register ignores CPU writes whose address does not decode per R1. Examples are 0x5012, 0x5003 and 0x9002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_src_ppu | input | 1 | Source select: 0 selects inner banking, 1 selects PPU low bits |
| mode_latch_off | input | 1 | Latch disable; ROM/RAM choice while inner banking is active |
| mode_size_half | input | 1 | Size bit that halves the outer window |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 3 | PPU address bits A12..A10 |
| inner_bank | input | 8 | 1 KiB bank number from the inner controller |
| chr_addr | output | 11 | Composed CHR address A20..A10 |
| chr_ram_sel | output | 1 | 1 selects CHR-RAM, 0 selects CHR-ROM |

## Verification
All eight mode combinations are swept for several base patterns. Each sweep runs against every PPU low-address value and against inner bank numbers that separately exercise the top bit, the lowest bit and an alternating pattern. This shows exactly which bits come from the base, the inner number, the latch or the PPU in each regime. The inner number changes while PPU bits are selected and the PPU bits change while inner banking is selected, so a leak from the wrong source shows up.

Latch loads are attempted in every regime, and the latch value is then read back through the latch-banked regime. Near-miss base addresses confirm that the decode mask is applied.

// File: rtl/outer_chr_pkg.sv
package outer_chr_pkg;

    localparam int BASE_W  = 8;
    localparam int INNER_W = 8;
    localparam int PPU_W   = 3;
    localparam int LATCH_W = 2;
    localparam int OUT_W   = BASE_W + PPU_W;

    typedef enum logic [2:0] {
        RG_INNER_WIDE,
        RG_INNER_NARROW,
        RG_LATCH_WIDE,
        RG_LATCH_NARROW,
        RG_FIXED
    } regime_e;

    typedef struct packed {
        logic src_ppu;
        logic latch_off;
        logic size_half;
    } chr_mode_t;

    function automatic regime_e classify(chr_mode_t m);
        regime_e r;
        if (!m.src_ppu)
            r = m.size_half ? RG_INNER_NARROW : RG_INNER_WIDE;
        else if (m.latch_off)
            r = RG_FIXED;
        else
            r = m.size_half ? RG_LATCH_NARROW : RG_LATCH_WIDE;
        return r;
    endfunction

    function automatic logic latch_active(chr_mode_t m);
        return m.src_ppu && !m.latch_off;
    endfunction

endpackage

// File: rtl/chr_base_reg.sv
module chr_base_reg
    import outer_chr_pkg::*;
#(
    parameter int          AW    = 16,
    parameter logic [15:0] MATCH = 16'h5002,
    parameter logic [15:0] MASK  = 16'hF013
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BASE_W-1:0] data,
    output logic [BASE_W-1:0] base_q
);
    logic hit;

    always_comb hit = wr && ((addr & MASK[AW-1:0]) == MATCH[AW-1:0]);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (hit)
            base_q <= data;
    end
endmodule

// File: rtl/chr_bank_latch.sv
module chr_bank_latch
    import outer_chr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               wr,
    input  logic [AW-1:0]      addr,
    input  logic [LATCH_W-1:0] data,
    output logic [LATCH_W-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (enable && wr && addr[AW-1])
            latch_q <= data;
    end
endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
    import outer_chr_pkg::*;
(
    input  regime_e             regime,
    input  logic [BASE_W-1:0]   base,
    input  logic [INNER_W-1:0]  inner,
    input  logic [LATCH_W-1:0]  latch,
    input  logic [PPU_W-1:0]    ppu,
    output logic [OUT_W-1:0]    addr
);
    always_comb begin
        unique case (regime)
            RG_INNER_WIDE:   addr = {base[7:5], inner[7:0]};
            RG_INNER_NARROW: addr = {base[7:4], inner[6:0]};
            RG_LATCH_WIDE:   addr = {base[7:2], latch[1:0], ppu};
            RG_LATCH_NARROW: addr = {base[7:1], latch[0], ppu};
            default:         addr = {base, ppu};
        endcase
    end
endmodule

// File: rtl/outer_chr_composer.sv
module outer_chr_composer
    import outer_chr_pkg::*;
#(
    parameter int          CPU_AW     = 16,
    parameter logic [15:0] BASE_MATCH = 16'h5002,
    parameter logic [15:0] BASE_MASK  = 16'hF013
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_src_ppu,
    input  logic               mode_latch_off,
    input  logic               mode_size_half,
    input  logic               cpu_wr,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [BASE_W-1:0]  cpu_data,
    input  logic [PPU_W-1:0]   ppu_addr,
    input  logic [INNER_W-1:0] inner_bank,
    output logic [OUT_W-1:0]   chr_addr,
    output logic               chr_ram_sel
);
    chr_mode_t          mode;
    regime_e            regime;
    logic [BASE_W-1:0]  base_q;
    logic [LATCH_W-1:0] latch_q;

    always_comb begin
        mode.src_ppu   = mode_src_ppu;
        mode.latch_off = mode_latch_off;
        mode.size_half = mode_size_half;
        regime         = classify(mode);
        chr_ram_sel    = !mode.src_ppu && mode.latch_off;
    end

    chr_base_reg #(.AW(CPU_AW), .MATCH(BASE_MATCH), .MASK(BASE_MASK)) u_base (
        .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr),
        .data(cpu_data), .base_q(base_q)
    );

    chr_bank_latch #(.AW(CPU_AW)) u_latch (
        .clk(clk), .rst(rst), .enable(latch_active(mode)), .wr(cpu_wr),
        .addr(cpu_addr), .data(cpu_data[LATCH_W-1:0]), .latch_q(latch_q)
    );

    chr_addr_mux u_mux (
        .regime(regime), .base(base_q), .inner(inner_bank),
        .latch(latch_q), .ppu(ppu_addr), .addr(chr_addr)
    );
endmodule

// File: rtl/outer_chr_checker.sv
module outer_chr_checker (
    input logic        clk,
    input logic        rst,
    input logic        mode_src_ppu,
    input logic        mode_latch_off,
    input logic        mode_size_half,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic [2:0]  ppu_addr,
    input logic [7:0]  inner_bank,
    input logic [10:0] chr_addr,
    input logic        chr_ram_sel,
    input logic [7:0]  base_q,
    input logic [1:0]  latch_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (base_q == 8'h00 && latch_q == 2'b00));

    p_base_load_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'h5 && cpu_addr[4] == 1'b0 && cpu_addr[1:0] == 2'b10)
        |=> base_q == $past(cpu_data));

    p_inner_low_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_src_ppu |-> chr_addr[6:0] == inner_bank[6:0]);

    p_ppu_low_r6: assert property (@(posedge clk) disable iff (rst)
        mode_src_ppu |-> chr_addr[2:0] == ppu_addr);

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(mode_src_ppu && !mode_latch_off && cpu_wr && cpu_addr[15]) |=> $stable(latch_q));

    p_ram_sel_r8: assert property (@(posedge clk) disable iff (rst)
        mode_src_ppu |-> !chr_ram_sel);
endmodule

bind outer_chr_composer outer_chr_checker u_chk (
    .clk(clk), .rst(rst),
    .mode_src_ppu(mode_src_ppu), .mode_latch_off(mode_latch_off),
    .mode_size_half(mode_size_half), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .inner_bank(inner_bank),
    .chr_addr(chr_addr), .chr_ram_sel(chr_ram_sel),
    .base_q(base_q), .latch_q(latch_q)
);

// File: tb/test_outer_chr_composer.sv
module test_outer_chr_composer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_src = 1'b0, m_off = 1'b0, m_half = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [2:0]  ppu = '0;
    logic [7:0]  inner = '0;
    logic [10:0] chr_addr;
    logic        chr_ram_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_base  = 0;
    int m_latch = 0;

    always #2 clk = ~clk;

    outer_chr_composer i_outer_chr_composer (
        .clk(clk), .rst(rst),
        .mode_src_ppu(m_src), .mode_latch_off(m_off), .mode_size_half(m_half),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .ppu_addr(ppu), .inner_bank(inner),
        .chr_addr(chr_addr), .chr_ram_sel(chr_ram_sel)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h0000;
    endtask

    function automatic int expect_addr(int b, int l, int s, int o, int h, int p, int n);
        int r;
        if (s == 0) begin
            if (h == 0) r = ((b >> 5) << 8) + n;
            else        r = ((b >> 4) << 7) + (n % 128);
        end else if (o == 1) begin
            r = b * 8 + p;
        end else if (h == 0) begin
            r = ((b >> 2) << 5) + ((l % 4) << 3) + p;
        end else begin
            r = ((b >> 1) << 4) + ((l % 2) << 3) + p;
        end
        return r;
    endfunction

    function automatic string req_of(int s, int o, int h);
        if (s == 0) return (h == 0) ? "R2" : "R3";
        if (o == 1) return "R6";
        return (h == 0) ? "R4" : "R5";
    endfunction

    task automatic sweep();
        int inners [4] = '{8'h00, 8'hFF, 8'h81, 8'h5A};
        for (int md = 0; md < 8; md++) begin
            @(negedge clk);
            m_src = md[2]; m_off = md[1]; m_half = md[0];
            for (int p = 0; p < 8; p++) begin
                for (int k = 0; k < 4; k++) begin
                    ppu = p[2:0]; inner = inners[k][7:0];
                    #0.5;
                    check(req_of(md / 4, (md / 2) % 2, md % 2), int'(chr_addr),
                          expect_addr(m_base, m_latch, md / 4, (md / 2) % 2, md % 2, p, inners[k]));
                    check("R8", int'(chr_ram_sel), (md / 4 == 0) ? (md / 2) % 2 : 0);
                end
            end
        end
    endtask

    task automatic set_latch_mode();
        @(negedge clk);
        m_src = 1'b1; m_off = 1'b0; m_half = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int bases [4] = '{8'hA5, 8'hFF, 8'h5A, 8'h13};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1/R7: reset state seen through fixed and latch regimes
        @(negedge clk);
        m_src = 1'b1; m_off = 1'b1; ppu = 3'd5;
        #0.5 check("R1", int'(chr_addr), 5);
        m_off = 1'b0;
        #0.5 check("R7", int'(chr_addr), 5);
        sweep();

        for (int i = 0; i < 4; i++) begin
            cpu_write(16'h5002, bases[i][7:0]);
            m_base = bases[i];
            set_latch_mode();
            cpu_write(16'h8000 + 16'(i * 16'h1111), 8'hFC | 8'(i));
            m_latch = i;
            sweep();
        end

        // R9: near-miss base addresses are ignored
        cpu_write(16'h5012, 8'h11);
        cpu_write(16'h5003, 8'h22);
        cpu_write(16'h9002, 8'h33);
        @(negedge clk);
        m_src = 1'b1; m_off = 1'b1; ppu = 3'd0;
        #0.5 check("R9", int'(chr_addr), m_base * 8);
        // R1: decode ignores masked-out bits (0x5FE6 & 0xF013 == 0x5002)
        cpu_write(16'h5FE6, 8'hC3);
        m_base = 8'hC3;
        #0.5 check("R1", int'(chr_addr), m_base * 8);

        // R7: CPU writes outside latch mode, or below 0x8000, leave the latch unchanged
        for (int md = 0; md < 8; md++) begin
            if (md == 4 || md == 5) continue;
            @(negedge clk);
            m_src = md[2]; m_off = md[1]; m_half = md[0];
            cpu_write(16'hC000, 8'h02);
            set_latch_mode();
            ppu = 3'd1;
            #0.5 check("R7", int'(chr_addr), expect_addr(m_base, m_latch, 1, 0, 0, 1, 0));
        end
        set_latch_mode();
        cpu_write(16'h7FFF, 8'h01);
        #0.5 check("R7", int'(chr_addr), expect_addr(m_base, m_latch, 1, 0, 0, 1, 0));
        // R7: narrow latch mode also loads the latch
        @(negedge clk);
        m_half = 1'b1;
        cpu_write(16'hFFFF, 8'h01);
        m_latch = 1;
        #0.5 check("R5", int'(chr_addr), expect_addr(m_base, m_latch, 1, 0, 1, 1, 0));
        @(negedge clk);
        m_half = 1'b0;
        #0.5 check("R7", int'(chr_addr), expect_addr(m_base, m_latch, 1, 0, 0, 1, 0));

        // R1/R7: reset clears both registers again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_base = 0; m_latch = 0;
        sweep();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule